// File: doc/BRIEF.md
# Linear CCD Clock Timing Generator

This block drives a three-colour linear CCD image sensor from one fast system clock. Each line opens with a readout-gate pulse, which goes to all three colour channels at once. Two complementary transfer clocks then shift the line out, and a reset clock gives one pulse per pixel. A one-clock sample strobe tells a downstream converter when the settled pixel voltage is valid. A one-clock line-start strobe and a busy flag frame each line for the capture logic.

All timing is counted in system clocks. With a 100 MHz system clock the resolution is 10 ns. The pixel period, the transfer cycles per line, the gate setup, width and recovery times, and the reset-pulse offset and width are programmable. Each of these is raised to a safe floor when it is set below that floor. The floors are parameters, and their defaults are sized for a 100 MHz clock. The whole setting is captured once, when a line sequence begins. Writes made during a line therefore do not disturb the line in progress.

Top module: `ccd_clock_gen`

## Requirements
- R1: Each line runs four phases in this order: gate setup, gate pulse, gate recovery, then transfers. The gate outputs for all channels are identical on every clock. During the setup, gate and recovery phases, and while idle, `phi1` is held high and `phi2` is held low.
- R2: The setup phase lasts max(`cfg_gate_lead`, 5) clocks. The gate pulse lasts max(`cfg_gate_width`, 80) clocks. The recovery phase lasts max(`cfg_gate_trail`, 80) clocks.
- R3: Let the pixel period be P = max(`cfg_pix_period`, 34) clocks. Let pixel clock index k run from 0 to P-1. In the transfer phase, `phi1` is low for k < floor(P/2) and high otherwise, and `phi2` is always the inverse of `phi1`.
- R4: The transfer phase holds max(`cfg_line_cycles`, LINE_MIN_CYC) pixel periods. LINE_MIN_CYC defaults to 2770. As a result, `phi1` falls exactly that many times between consecutive gate pulses.
- R5: Let D = max(`cfg_rs_delay`, 8) and W = max(`cfg_rs_width`, 5). `phi_rs` is high for D <= k < D+W and is cut off at the end of the pixel. `phi_rs` is low outside the transfer phase.
- R6: `adc_sample` is high for one clock when k = D + W + `cfg_smp_delay`, which is that many clocks after `phi_rs` falls. If that index is P or greater, there is no strobe for that pixel. `adc_sample` is never high outside the transfer phase.
- R7: `line_start` is high for exactly one clock: the first clock after the gate pulse falls.
- R8: `busy` is high on exactly the clocks of the transfer phase.
- R9: All configuration inputs are sampled only on the clock that enters the setup phase. A write at any other time first takes effect with the next line.
- R10: With `en` high and the block idle, a line sequence begins on the next clock. A line ends and the next begins immediately while `en` stays high. If `en` drops, the current line completes and the block goes idle.
- R11: Every output is registered and reflects the sequence state of the previous clock. After reset, and while idle, all outputs are low except `phi1`, which is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable for continuous line sequencing |
| cfg_pix_period | input | 16 | System clocks per pixel |
| cfg_line_cycles | input | 16 | Transfer cycles per line |
| cfg_gate_lead | input | 16 | Clocks from the last transfer edge to the gate rise |
| cfg_gate_width | input | 16 | Gate pulse high time in clocks |
| cfg_gate_trail | input | 16 | Clocks from the gate fall to the first transfer edge |
| cfg_rs_delay | input | 16 | Offset of the reset pulse from the `phi1` fall |
| cfg_rs_width | input | 16 | Reset pulse high time in clocks |
| cfg_smp_delay | input | 16 | Clocks from the reset pulse fall to the sample strobe |
| gate_out | output | 3 | Readout-gate pulses; bit 0 is red, bit 1 is green, bit 2 is blue |
| phi1 | output | 1 | Transfer clock phase 1 |
| phi2 | output | 1 | Transfer clock phase 2 |
| phi_rs | output | 1 | Output-node reset clock |
| adc_sample | output | 1 | Converter sample strobe |
| line_start | output | 1 | One-clock strobe after the gate pulse |
| busy | output | 1 | High during the transfer phase |

## Verification
Two events can fall on the same clock. One is the end of the last transfer cycle, where the next line's configuration is captured. The other is a configuration write made on that exact clock. The bench tracks its own model of the line timing, finds the clock just before that capture edge, and drives new settings there. It then expects the very next line to use them in full, and it checks the pixel count, strobe count and every output against the model on every clock. A second same-cycle case is a zero sample delay, which places the sample strobe on the clock the reset pulse falls. This case is judged by the per-clock comparison and by a count of exactly one strobe per pixel.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;

    localparam int CNT_W = 16;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_GATE  = 3'd2,
        ST_TRAIL = 3'd3,
        ST_XFER  = 3'd4
    } seq_state_t;

    typedef struct packed {
        cnt_t pix_period;
        cnt_t line_cycles;
        cnt_t gate_lead;
        cnt_t gate_width;
        cnt_t gate_trail;
        cnt_t rs_delay;
        cnt_t rs_width;
        cnt_t smp_delay;
    } timing_cfg_t;

    function automatic cnt_t at_least(cnt_t value, cnt_t floor_v);
        return (value < floor_v) ? floor_v : value;
    endfunction

    function automatic cnt_t inc_sat(cnt_t value);
        return (value == '1) ? value : value + cnt_t'(1);
    endfunction

endpackage

// File: rtl/ccd_cfg_latch.sv
module ccd_cfg_latch
    import ccd_tg_pkg::*;
#(
    parameter int PIX_MIN   = 34,
    parameter int LINE_MIN  = 2770,
    parameter int LEAD_MIN  = 5,
    parameter int GATE_MIN  = 80,
    parameter int TRAIL_MIN = 80,
    parameter int RSD_MIN   = 8,
    parameter int RSW_MIN   = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  timing_cfg_t raw,
    output timing_cfg_t cfg
);

    timing_cfg_t limited;

    always_comb begin
        limited.pix_period  = at_least(raw.pix_period,  cnt_t'(PIX_MIN));
        limited.line_cycles = at_least(raw.line_cycles, cnt_t'(LINE_MIN));
        limited.gate_lead   = at_least(raw.gate_lead,   cnt_t'(LEAD_MIN));
        limited.gate_width  = at_least(raw.gate_width,  cnt_t'(GATE_MIN));
        limited.gate_trail  = at_least(raw.gate_trail,  cnt_t'(TRAIL_MIN));
        limited.rs_delay    = at_least(raw.rs_delay,    cnt_t'(RSD_MIN));
        limited.rs_width    = at_least(raw.rs_width,    cnt_t'(RSW_MIN));
        limited.smp_delay   = raw.smp_delay;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.pix_period  <= cnt_t'(PIX_MIN);
            cfg.line_cycles <= cnt_t'(LINE_MIN);
            cfg.gate_lead   <= cnt_t'(LEAD_MIN);
            cfg.gate_width  <= cnt_t'(GATE_MIN);
            cfg.gate_trail  <= cnt_t'(TRAIL_MIN);
            cfg.rs_delay    <= cnt_t'(RSD_MIN);
            cfg.rs_width    <= cnt_t'(RSW_MIN);
            cfg.smp_delay   <= '0;
        end else if (load) begin
            cfg <= limited;
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cfg)); // R9
    AST_PIX_FLOOR: assert property (@(posedge clk) disable iff (rst)
        cfg.pix_period >= cnt_t'(PIX_MIN)); // R3
    AST_GATE_FLOOR: assert property (@(posedge clk) disable iff (rst)
        cfg.gate_width >= cnt_t'(GATE_MIN) && cfg.gate_trail >= cnt_t'(TRAIL_MIN)); // R2

endmodule

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
    import ccd_tg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  cnt_t       pix_period,
    input  cnt_t       line_cycles,
    input  cnt_t       gate_lead,
    input  cnt_t       gate_width,
    input  cnt_t       gate_trail,
    output seq_state_t state,
    output cnt_t       pix_k,
    output logic       load,
    output logic       first_trail
);

    cnt_t seg_cnt;
    cnt_t pix_n;
    logic pix_last;
    logic line_last;
    logic seg_last;

    always_comb begin
        pix_last  = (pix_k == pix_period - cnt_t'(1));
        line_last = (pix_n == line_cycles - cnt_t'(1));
        unique case (state)
            ST_LEAD:  seg_last = (seg_cnt == gate_lead  - cnt_t'(1));
            ST_GATE:  seg_last = (seg_cnt == gate_width - cnt_t'(1));
            ST_TRAIL: seg_last = (seg_cnt == gate_trail - cnt_t'(1));
            default:  seg_last = 1'b0;
        endcase
        load = en && ((state == ST_IDLE) ||
                      (state == ST_XFER && pix_last && line_last));
        first_trail = (state == ST_TRAIL) && (seg_cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            seg_cnt <= '0;
            pix_k   <= '0;
            pix_n   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (en) begin
                        state   <= ST_LEAD;
                        seg_cnt <= '0;
                    end
                end
                ST_LEAD: begin
                    if (seg_last) begin
                        state   <= ST_GATE;
                        seg_cnt <= '0;
                    end else begin
                        seg_cnt <= seg_cnt + cnt_t'(1);
                    end
                end
                ST_GATE: begin
                    if (seg_last) begin
                        state   <= ST_TRAIL;
                        seg_cnt <= '0;
                    end else begin
                        seg_cnt <= seg_cnt + cnt_t'(1);
                    end
                end
                ST_TRAIL: begin
                    if (seg_last) begin
                        state <= ST_XFER;
                        pix_k <= '0;
                        pix_n <= '0;
                    end else begin
                        seg_cnt <= seg_cnt + cnt_t'(1);
                    end
                end
                ST_XFER: begin
                    if (pix_last) begin
                        pix_k <= '0;
                        if (line_last) begin
                            state   <= en ? ST_LEAD : ST_IDLE;
                            seg_cnt <= '0;
                            pix_n   <= '0;
                        end else begin
                            pix_n <= pix_n + cnt_t'(1);
                        end
                    end else begin
                        pix_k <= pix_k + cnt_t'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_PIX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        state == ST_XFER |-> pix_k < pix_period); // R3
    AST_LINE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        state == ST_XFER |-> pix_n < line_cycles); // R4
    AST_IDLE_NEEDS_DROP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_XFER && load) |=> state == ST_LEAD); // R10

endmodule

// File: rtl/ccd_pix_decode.sv
module ccd_pix_decode
    import ccd_tg_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_state_t        state,
    input  cnt_t              pix_k,
    input  logic              first_trail,
    input  cnt_t              pix_period,
    input  cnt_t              rs_delay,
    input  cnt_t              rs_width,
    input  cnt_t              smp_delay,
    output logic [NUM_CH-1:0] gate_q,
    output logic              phi1_q,
    output logic              phi2_q,
    output logic              rs_q,
    output logic              smp_q,
    output logic              ls_q,
    output logic              busy_q
);

    localparam int RS_W  = CNT_W + 1;
    localparam int SMP_W = CNT_W + 2;

    logic             in_xfer;
    cnt_t             half;
    logic [RS_W-1:0]  rs_end;
    logic [SMP_W-1:0] smp_at;
    logic             n_gate, n_phi1, n_phi2, n_rs, n_smp;

    always_comb begin
        in_xfer = (state == ST_XFER);
        half    = pix_period >> 1;
        rs_end  = {1'b0, rs_delay} + {1'b0, rs_width};
        smp_at  = {1'b0, rs_end} + {2'b00, smp_delay};
        n_gate  = (state == ST_GATE);
        n_phi1  = !in_xfer || (pix_k >= half);
        n_phi2  = in_xfer && (pix_k < half);
        n_rs    = in_xfer && (pix_k >= rs_delay) && ({1'b0, pix_k} < rs_end);
        n_smp   = in_xfer && ({2'b00, pix_k} == smp_at);
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_gate
        always_ff @(posedge clk) begin
            if (rst) gate_q[ch] <= 1'b0;
            else     gate_q[ch] <= n_gate;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phi1_q <= 1'b1;
            phi2_q <= 1'b0;
            rs_q   <= 1'b0;
            smp_q  <= 1'b0;
            ls_q   <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            phi1_q <= n_phi1;
            phi2_q <= n_phi2;
            rs_q   <= n_rs;
            smp_q  <= n_smp;
            ls_q   <= first_trail;
            busy_q <= in_xfer;
        end
    end

    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (rst)
        phi1_q != phi2_q); // R3
    AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        gate_q[0] |-> phi1_q && !phi2_q && !busy_q); // R1
    AST_RS_IN_XFER: assert property (@(posedge clk) disable iff (rst)
        rs_q |-> busy_q); // R5
    AST_SMP_AFTER_RS: assert property (@(posedge clk) disable iff (rst)
        smp_q |-> busy_q && !rs_q); // R6
    AST_LS_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        ls_q |-> $past(gate_q[0]) && !gate_q[0]); // R7

endmodule

// File: rtl/ccd_clock_gen.sv
module ccd_clock_gen
    import ccd_tg_pkg::*;
#(
    parameter int NUM_CH       = 3,
    parameter int PIX_MIN      = 34,
    parameter int LINE_MIN_CYC = 2770,
    parameter int LEAD_MIN     = 5,
    parameter int GATE_MIN     = 80,
    parameter int TRAIL_MIN    = 80,
    parameter int RSD_MIN      = 8,
    parameter int RSW_MIN      = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [CNT_W-1:0]  cfg_pix_period,
    input  logic [CNT_W-1:0]  cfg_line_cycles,
    input  logic [CNT_W-1:0]  cfg_gate_lead,
    input  logic [CNT_W-1:0]  cfg_gate_width,
    input  logic [CNT_W-1:0]  cfg_gate_trail,
    input  logic [CNT_W-1:0]  cfg_rs_delay,
    input  logic [CNT_W-1:0]  cfg_rs_width,
    input  logic [CNT_W-1:0]  cfg_smp_delay,
    output logic [NUM_CH-1:0] gate_out,
    output logic              phi1,
    output logic              phi2,
    output logic              phi_rs,
    output logic              adc_sample,
    output logic              line_start,
    output logic              busy
);

    timing_cfg_t raw_cfg;
    timing_cfg_t cfg;
    seq_state_t  state;
    cnt_t        pix_k;
    logic        load;
    logic        first_trail;

    always_comb begin
        raw_cfg.pix_period  = cfg_pix_period;
        raw_cfg.line_cycles = cfg_line_cycles;
        raw_cfg.gate_lead   = cfg_gate_lead;
        raw_cfg.gate_width  = cfg_gate_width;
        raw_cfg.gate_trail  = cfg_gate_trail;
        raw_cfg.rs_delay    = cfg_rs_delay;
        raw_cfg.rs_width    = cfg_rs_width;
        raw_cfg.smp_delay   = cfg_smp_delay;
    end

    ccd_cfg_latch #(
        .PIX_MIN  (PIX_MIN),
        .LINE_MIN (LINE_MIN_CYC),
        .LEAD_MIN (LEAD_MIN),
        .GATE_MIN (GATE_MIN),
        .TRAIL_MIN(TRAIL_MIN),
        .RSD_MIN  (RSD_MIN),
        .RSW_MIN  (RSW_MIN)
    ) u_cfg (
        .clk (clk),
        .rst (rst),
        .load(load),
        .raw (raw_cfg),
        .cfg (cfg)
    );

    ccd_line_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .pix_period (cfg.pix_period),
        .line_cycles(cfg.line_cycles),
        .gate_lead  (cfg.gate_lead),
        .gate_width (cfg.gate_width),
        .gate_trail (cfg.gate_trail),
        .state      (state),
        .pix_k      (pix_k),
        .load       (load),
        .first_trail(first_trail)
    );

    ccd_pix_decode #(
        .NUM_CH(NUM_CH)
    ) u_dec (
        .clk        (clk),
        .rst        (rst),
        .state      (state),
        .pix_k      (pix_k),
        .first_trail(first_trail),
        .pix_period (cfg.pix_period),
        .rs_delay   (cfg.rs_delay),
        .rs_width   (cfg.rs_width),
        .smp_delay  (cfg.smp_delay),
        .gate_q     (gate_out),
        .phi1_q     (phi1),
        .phi2_q     (phi2),
        .rs_q       (phi_rs),
        .smp_q      (adc_sample),
        .ls_q       (line_start),
        .busy_q     (busy)
    );

    // Window counters that watch the pins, for the width and count properties
    logic gate_d;
    logic phi1_d;
    logic line_seen;
    cnt_t gate_len;
    cnt_t xfer_falls;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_d     <= 1'b0;
            phi1_d     <= 1'b1;
            line_seen  <= 1'b0;
            gate_len   <= '0;
            xfer_falls <= '0;
        end else begin
            gate_d   <= gate_out[0];
            phi1_d   <= phi1;
            gate_len <= gate_out[0] ? inc_sat(gate_len) : '0;
            if (gate_out[0] && !gate_d) begin
                xfer_falls <= '0;
                line_seen  <= 1'b1;
            end else if (phi1_d && !phi1) begin
                xfer_falls <= inc_sat(xfer_falls);
            end
        end
    end

    AST_GATE_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (gate_d && !gate_out[0]) |-> gate_len >= cnt_t'(GATE_MIN)); // R2
    AST_LINE_MIN_CYC: assert property (@(posedge clk) disable iff (rst)
        (gate_out[0] && !gate_d && line_seen) |-> xfer_falls >= cnt_t'(LINE_MIN_CYC)); // R4
    AST_GATES_MATCH: assert property (@(posedge clk) disable iff (rst)
        gate_out == {NUM_CH{gate_out[0]}}); // R1
    AST_BUSY_NO_GATE: assert property (@(posedge clk) disable iff (rst)
        busy |-> gate_out == '0); // R8

endmodule

// File: tb/tb_ccd_clock_gen.sv
`timescale 1ns/100ps
module tb_ccd_clock_gen;

    localparam int LINE_MIN = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [15:0] c_pix = '0, c_line = '0, c_lead = '0, c_gw = '0;
    logic [15:0] c_tr = '0, c_rd = '0, c_rw = '0, c_sd = '0;
    logic [2:0]  gate_out;
    logic        phi1, phi2, phi_rs, adc_sample, line_start, busy;

    always #2.5 clk = ~clk;

    ccd_clock_gen #(.LINE_MIN_CYC(LINE_MIN)) dut (
        .clk(clk), .rst(rst), .en(en),
        .cfg_pix_period(c_pix), .cfg_line_cycles(c_line),
        .cfg_gate_lead(c_lead), .cfg_gate_width(c_gw), .cfg_gate_trail(c_tr),
        .cfg_rs_delay(c_rd), .cfg_rs_width(c_rw), .cfg_smp_delay(c_sd),
        .gate_out(gate_out), .phi1(phi1), .phi2(phi2), .phi_rs(phi_rs),
        .adc_sample(adc_sample), .line_start(line_start), .busy(busy)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Behavioural timeline model: one time index t within the line
    bit m_run = 0;
    int m_t = 0, m_total = 0;
    int m_lead, m_gw, m_tr, m_p, m_l, m_rd, m_rw, m_sd;
    bit e_gate = 0, e_phi1 = 1, e_phi2 = 0, e_rs = 0, e_smp = 0, e_ls = 0, e_busy = 0;
    bit started = 0;

    task automatic m_capture();
        m_p    = mx(int'(c_pix), 34);
        m_l    = mx(int'(c_line), LINE_MIN);
        m_lead = mx(int'(c_lead), 5);
        m_gw   = mx(int'(c_gw), 80);
        m_tr   = mx(int'(c_tr), 80);
        m_rd   = mx(int'(c_rd), 8);
        m_rw   = mx(int'(c_rw), 5);
        m_sd   = int'(c_sd);
        m_total = m_lead + m_gw + m_tr + m_l * m_p;
    endtask

    always @(posedge clk) begin
        started = 1;
        e_gate = 0; e_phi1 = 1; e_phi2 = 0; e_rs = 0; e_smp = 0; e_ls = 0; e_busy = 0;
        if (rst) begin
            m_run = 0;
            m_t = 0;
        end else begin
            if (m_run) begin
                if (m_t < m_lead) begin
                end else if (m_t < m_lead + m_gw) begin
                    e_gate = 1;
                end else if (m_t < m_lead + m_gw + m_tr) begin
                    e_ls = (m_t == m_lead + m_gw);
                end else begin
                    int off, k;
                    off = m_t - (m_lead + m_gw + m_tr);
                    k = off % m_p;
                    e_busy = 1;
                    e_phi1 = (k >= m_p / 2);
                    e_phi2 = !e_phi1;
                    e_rs = (k >= m_rd) && (k < m_rd + m_rw);
                    e_smp = (k == m_rd + m_rw + m_sd);
                end
                m_t++;
                if (m_t == m_total) begin
                    if (en) begin
                        m_t = 0;
                        m_capture();
                    end else begin
                        m_run = 0;
                    end
                end
            end else if (en) begin
                m_run = 1;
                m_t = 0;
                m_capture();
            end
        end
    end

    // Per-clock comparison plus line-level measurements
    int rises = 0, falls = 0, last_falls = 0, smp_cnt = 0, last_smp = 0;
    int ls_cnt = 0, last_ls = 0, gw_run = 0, last_gw = 0;
    bit p_gate = 0, p_phi1 = 1;

    always @(negedge clk) begin
        if (started) begin
            chk(gate_out[0] == gate_out[1] && gate_out[1] == gate_out[2], "R1", int'(gate_out), int'({3{gate_out[0]}}));
            chk(gate_out[0] == e_gate, "R2", int'(gate_out[0]), int'(e_gate));
            chk(phi1 == e_phi1 && phi2 == e_phi2, "R3", int'({phi1, phi2}), int'({e_phi1, e_phi2}));
            chk(phi_rs == e_rs, "R5", int'(phi_rs), int'(e_rs));
            chk(adc_sample == e_smp, "R6", int'(adc_sample), int'(e_smp));
            chk(line_start == e_ls, "R7", int'(line_start), int'(e_ls));
            chk(busy == e_busy, "R8", int'(busy), int'(e_busy));
            if (gate_out[0] && !p_gate) begin
                rises++;
                last_falls = falls; falls = 0;
                last_smp = smp_cnt; smp_cnt = 0;
                last_ls = ls_cnt; ls_cnt = 0;
            end
            if (gate_out[0]) gw_run++;
            if (!gate_out[0] && p_gate) begin
                last_gw = gw_run;
                gw_run = 0;
            end
            if (!phi1 && p_phi1) falls++;
            if (adc_sample) smp_cnt++;
            if (line_start) ls_cnt++;
            p_gate = gate_out[0];
            p_phi1 = phi1;
        end
    end

    task automatic wait_rises(input int target);
        while (rises < target) @(negedge clk);
    endtask

    task automatic set_cfg(input int p, l, ld, gw, tr, rd, rw, sd);
        c_pix = 16'(p); c_line = 16'(l); c_lead = 16'(ld); c_gw = 16'(gw);
        c_tr = 16'(tr); c_rd = 16'(rd); c_rw = 16'(rw); c_sd = 16'(sd);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R11 reset and idle state
        chk(phi1 == 1 && phi2 == 0 && gate_out == 0 && !busy && !phi_rs && !adc_sample && !line_start,
            "R11", int'({phi1, phi2, gate_out, busy}), 32);

        // Everything at zero: all floors apply (R2, R4)
        en = 1'b1;
        wait_rises(2);
        chk(last_falls == LINE_MIN, "R4", last_falls, LINE_MIN);
        chk(last_gw == 80, "R2", last_gw, 80);
        chk(last_ls == 1, "R7", last_ls, 1);

        // Mid-line write: current line keeps its settings (R9)
        repeat (200) @(negedge clk);
        set_cfg(100, 50, 10, 100, 100, 25, 10, 5);
        wait_rises(3);
        chk(last_falls == LINE_MIN, "R9", last_falls, LINE_MIN);
        wait_rises(4);
        chk(last_falls == 50, "R4", last_falls, 50);
        chk(last_gw == 100, "R2", last_gw, 100);
        chk(last_smp == 50, "R6", last_smp, 50);
        chk(last_ls == 1, "R7", last_ls, 1);

        // Odd period, sample index beyond the pixel end
        repeat (300) @(negedge clk);
        set_cfg(35, 3, 0, 0, 0, 8, 5, 30);
        wait_rises(6);
        chk(last_falls == LINE_MIN, "R4", last_falls, LINE_MIN);
        chk(last_smp == 0, "R6", last_smp, 0);

        // Write on the capture clock itself, zero sample delay
        while (!(m_run && m_t == m_total - 1)) @(negedge clk);
        set_cfg(40, 45, 6, 90, 85, 10, 6, 0);
        wait_rises(8);
        chk(last_falls == 45, "R9", last_falls, 45);
        chk(last_smp == 45, "R6", last_smp, 45);
        chk(last_gw == 90, "R2", last_gw, 90);

        // Drop enable mid-line: line completes then idles (R10)
        repeat (300) @(negedge clk);
        en = 1'b0;
        while (busy) @(negedge clk);
        begin
            int r0;
            r0 = rises;
            repeat (300) @(negedge clk);
            chk(rises == r0, "R10", rises, r0);
            chk(phi1 == 1 && !busy && gate_out == 0, "R10", int'({phi1, busy}), 2);
            en = 1'b1;
            repeat (100) @(negedge clk);
            chk(rises == r0 + 1, "R10", rises, r0 + 1);
        end
        finish_run();
    end

endmodule